// File: doc/BRIEF.md
# Slave Shift-Clock Rate Monitor

This block sits beside the shift logic of an SPI slave. It measures the time between rising edges of the already synchronized shift clock in module-clock cycles and compares that period with the slave's own programmed bit period. The programmed period must equal the master's rate. When a period comes out longer than twice the programmed value, or shorter than half of it, the monitor reports a rate error. Such an error is the sign of a missing pulse or of a spurious extra pulse inside a frame.

A rate error sets a sticky flag, which stays set until `err_clr_i` clears it. It also raises a one-cycle interrupt pulse when interrupts are enabled, and a one-cycle reset pulse to the serial core when automatic reset is enabled. When the next frame's data has been loaded before the current frame ends, the monitor keeps measuring across the frame boundary, because the master is then expected to continue the clock. If the master stops instead, the stall is reported. With no load pending, the clock may idle freely after a frame.

A controller with four states drives the monitor:
- OFF: the slave is inactive.
- WAIT: the monitor waits for the first edge of a frame, and the counter is stopped.
- RUN: the monitor measures inside a frame.
- CHAIN: a frame has ended with the next frame pending, and the counter keeps running.

The transitions are:
- OFF→WAIT when the slave becomes active and no edge arrives.
- OFF/WAIT→RUN on a rising edge.
- RUN→CHAIN on frame end when a load is pending.
- RUN→WAIT on frame end when no load is pending, or on an error.
- CHAIN→RUN on a rising edge.
- CHAIN→WAIT on an error.
- Any state→OFF when the slave becomes inactive.

Top module: `sclk_rate_mon`

## Requirements
- R1: Checking takes place only while `slave_en_i` is high. Dropping it returns the monitor to OFF, clears any pending load, and produces no error however the clock behaves.
- R2: A rising edge in OFF or WAIT starts a measurement and never raises an error. The measured period is the number of module-clock cycles from one rising edge to the next.
- R3: While a measurement runs, an error is raised in the cycle in which the elapsed count exceeds 2×P, where P is `exp_period_i`. The monitor does not wait for the next edge. `err_flag_o` shows the error one cycle later.
- R4: Inside a frame, a rising edge whose period is below floor(P/2) raises an error. Periods of exactly floor(P/2) and exactly 2×P raise none.
- R5: `err_flag_o` stays at 1 after an error until a cycle with `err_clr_i` high and no new error. A new error takes precedence over a clear in the same cycle.
- R6: `err_irq_o` is a one-cycle pulse, one cycle after each error, and only when `irq_en_i` was high in the error cycle.
- R7: `core_rst_o` is a one-cycle pulse, one cycle after each error, and only when `arst_en_i` was high in the error cycle. It does not clear `err_flag_o`.
- R8: A `frame_done_i` pulse in RUN with no pending load stops the counter and enters WAIT. Any length of clock idling after that raises no error.
- R9: A `tx_loaded_i` pulse seen in RUN or CHAIN (or in the same cycle as the frame end) makes the frame end enter CHAIN. The counter keeps running there, so a master that stops the clock produces the R3 error.
- R10: The first rising edge in CHAIN is exempt from the R4 check, restarts the measurement, and returns to RUN.
- R11: After an error the monitor enters WAIT, so the next rising edge is treated as the first edge of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Shift clock, already synchronized to clk_i; rising edge is the measured edge |
| slave_en_i | input | 1 | Slave mode active |
| frame_done_i | input | 1 | One-cycle pulse at the end of a frame |
| tx_loaded_i | input | 1 | One-cycle pulse when the next frame's data is loaded |
| exp_period_i | input | PER_W | Programmed bit period P in module-clock cycles |
| irq_en_i | input | 1 | Enables the interrupt pulse |
| arst_en_i | input | 1 | Enables the core reset pulse |
| err_clr_i | input | 1 | Clears the sticky error flag |
| err_flag_o | output | 1 | Sticky rate error flag |
| err_irq_o | output | 1 | Gated interrupt pulse |
| core_rst_o | output | 1 | Reset pulse to the serial core |

## Verification
The assertions take for granted the following about the inputs: `exp_period_i` is at least 2 and does not change while the slave is active; `frame_done_i` and `tx_loaded_i` are single-cycle pulses; and `sclk_i` is low when reset is released. The stimulus keeps P fixed at 8 and changes all inputs only on the falling clock edge. Each frame-end or load indication is one cycle long, and every clock gap it drives is at least two cycles, so each rising edge is distinct.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_CHAIN = 2'd3
    } srm_state_e;

endpackage

// File: rtl/srm_edge.sv
module srm_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    output logic rise_o
);

    logic sclk_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
        end
    end

    assign rise_o = sclk_i & ~sclk_q;

endmodule

// File: rtl/srm_cnt.sv
module srm_cnt #(
    parameter int CW = 14
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          restart_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/srm_fsm.sv
module srm_fsm
    import srm_pkg::*;
#(
    parameter int PER_W = 12,
    parameter int CW    = PER_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             slave_en_i,
    input  logic             rise_i,
    input  logic             frame_done_i,
    input  logic             tx_loaded_i,
    input  logic [PER_W-1:0] exp_period_i,
    input  logic [CW-1:0]    cnt_i,
    output logic             err_evt_o,
    output logic             run_o,
    output srm_state_e       state_o
);

    srm_state_e    state_q, state_d;
    logic          pend_q, pend_d;
    logic [CW-1:0] half_lim, dbl_lim;
    logic          counting, too_slow, too_fast;

    assign half_lim = CW'(exp_period_i >> 1);
    assign dbl_lim  = CW'(exp_period_i) << 1;

    assign counting  = (state_q == ST_RUN) || (state_q == ST_CHAIN);
    assign too_slow  = counting && (cnt_i > dbl_lim);
    assign too_fast  = (state_q == ST_RUN) && rise_i && (cnt_i < half_lim);
    assign err_evt_o = slave_en_i && (too_slow || too_fast);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!slave_en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = rise_i ? ST_RUN : ST_WAIT;
                end
                ST_WAIT: begin
                    if (rise_i) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (err_evt_o) begin
                        state_d = ST_WAIT;
                    end else if (frame_done_i) begin
                        state_d = (pend_q || tx_loaded_i) ? ST_CHAIN : ST_WAIT;
                    end
                end
                ST_CHAIN: begin
                    if (err_evt_o) begin
                        state_d = ST_WAIT;
                    end else if (rise_i) begin
                        state_d = ST_RUN;
                    end
                end
            endcase
        end
    end

    // outputs and pending-load bookkeeping
    always_comb begin
        run_o  = (state_d == ST_RUN) || (state_d == ST_CHAIN);
        pend_d = pend_q;
        if (!slave_en_i || !counting || err_evt_o) begin
            pend_d = 1'b0;
        end else if ((state_q == ST_RUN) && frame_done_i) begin
            pend_d = 1'b0;
        end else if (tx_loaded_i) begin
            pend_d = 1'b1;
        end
    end

    assign state_o = state_q;

    AST_CHAIN_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CHAIN) |-> ($past(state_q) == ST_RUN || $past(state_q) == ST_CHAIN)); // R9

    AST_ERR_TO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_evt_o |=> (state_q == ST_WAIT || state_q == ST_OFF)); // R11

endmodule

// File: rtl/sclk_rate_mon.sv
module sclk_rate_mon
    import srm_pkg::*;
#(
    parameter int PER_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sclk_i,
    input  logic             slave_en_i,
    input  logic             frame_done_i,
    input  logic             tx_loaded_i,
    input  logic [PER_W-1:0] exp_period_i,
    input  logic             irq_en_i,
    input  logic             arst_en_i,
    input  logic             err_clr_i,
    output logic             err_flag_o,
    output logic             err_irq_o,
    output logic             core_rst_o
);

    localparam int CW = PER_W + 2;

    logic          rise;
    logic          err_evt;
    logic          run;
    logic [CW-1:0] cnt;
    srm_state_e    state;

    srm_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_i (sclk_i),
        .rise_o (rise)
    );

    srm_cnt #(.CW(CW)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (rise),
        .cnt_o     (cnt)
    );

    srm_fsm #(.PER_W(PER_W), .CW(CW)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slave_en_i   (slave_en_i),
        .rise_i       (rise),
        .frame_done_i (frame_done_i),
        .tx_loaded_i  (tx_loaded_i),
        .exp_period_i (exp_period_i),
        .cnt_i        (cnt),
        .err_evt_o    (err_evt),
        .run_o        (run),
        .state_o      (state)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_flag_o <= 1'b0;
            err_irq_o  <= 1'b0;
            core_rst_o <= 1'b0;
        end else begin
            if (err_evt) begin
                err_flag_o <= 1'b1;
            end else if (err_clr_i) begin
                err_flag_o <= 1'b0;
            end
            err_irq_o  <= err_evt & irq_en_i;
            core_rst_o <= err_evt & arst_en_i;
        end
    end

    AST_SLAVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_flag_o) |-> $past(slave_en_i)); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_flag_o && !err_clr_i) |=> err_flag_o); // R5

    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_irq_o |-> ($past(irq_en_i) && err_flag_o)); // R6

    AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |=> !core_rst_o); // R7

    AST_RST_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |-> err_flag_o); // R7

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_OFF || state == ST_WAIT) |-> (cnt == '0)); // R8

endmodule

// File: tb/sclk_rate_mon_tb_top.sv
module sclk_rate_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        slave_en = 1'b0;
    logic        frame_done = 1'b0;
    logic        tx_loaded = 1'b0;
    logic [11:0] exp_period = 12'(P);
    logic        irq_en = 1'b0;
    logic        arst_en = 1'b0;
    logic        err_clr = 1'b0;
    logic        err_flag, err_irq, core_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_rate_mon #(.PER_W(12)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sclk_i       (sclk),
        .slave_en_i   (slave_en),
        .frame_done_i (frame_done),
        .tx_loaded_i  (tx_loaded),
        .exp_period_i (exp_period),
        .irq_en_i     (irq_en),
        .arst_en_i    (arst_en),
        .err_clr_i    (err_clr),
        .err_flag_o   (err_flag),
        .err_irq_o    (err_irq),
        .core_rst_o   (core_rst)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    bit    finished = 1'b0;

    // behavioural reference: timestamps of edges instead of a counter
    int cyc = 0;
    int last_edge = 0;
    bit armed = 0, chained = 0, pend = 0, prev_s = 0;
    bit m_flag = 0, m_irq = 0, m_rst = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; last_edge = 0;
            armed = 0; chained = 0; pend = 0; prev_s = 0;
            m_flag = 0; m_irq = 0; m_rst = 0;
        end else begin
            bit rise, ev;
            int elapsed;
            cyc = cyc + 1;
            rise = sclk && !prev_s;
            prev_s = sclk;
            elapsed = cyc - last_edge;
            ev = 0;
            if (!slave_en) begin
                armed = 0; chained = 0; pend = 0;
            end else begin
                if (armed && elapsed > 2 * P) ev = 1;
                if (armed && !chained && rise && elapsed < P / 2) ev = 1;
                if (ev) begin
                    armed = 0; chained = 0; pend = 0;
                end else if (!armed) begin
                    if (rise) begin
                        armed = 1; chained = 0; last_edge = cyc;
                    end
                end else if (chained) begin
                    if (tx_loaded) pend = 1;
                    if (rise) begin
                        chained = 0; last_edge = cyc;
                    end
                end else begin
                    if (rise) last_edge = cyc;
                    if (frame_done) begin
                        if (pend || tx_loaded) chained = 1;
                        else armed = 0;
                        pend = 0;
                    end else if (tx_loaded) begin
                        pend = 1;
                    end
                end
            end
            m_flag = ev ? 1'b1 : (err_clr ? 1'b0 : m_flag);
            m_irq  = ev && irq_en;
            m_rst  = ev && arst_en;
        end
    end

    int irq_seen = 0;
    int rst_seen = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_cmp = n_cmp + 1;
            if (err_flag !== m_flag || err_irq !== m_irq || core_rst !== core_rst) begin
                n_bad = n_bad + 1;
                $display("FAIL %s model: flag/irq/rst act=%b%b%b exp=%b%b%b at cycle %0d",
                         cur_req, err_flag, err_irq, core_rst, m_flag, m_irq, m_rst, cyc);
            end else if (core_rst !== m_rst) begin
                n_bad = n_bad + 1;
                $display("FAIL %s model: core_rst act=%b exp=%b at cycle %0d",
                         cur_req, core_rst, m_rst, cyc);
            end
            if (err_irq === 1'b1) irq_seen = irq_seen + 1;
            if (core_rst === 1'b1) rst_seen = rst_seen + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    // rising edge now, then gap-1 low cycles
    task automatic rise_gap(input int gap);
        @(negedge clk);
        sclk = 1'b1;
        repeat (gap - 1) begin
            @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    // rising edge coinciding with the frame-end pulse
    task automatic rise_fd(input int gap);
        @(negedge clk);
        sclk = 1'b1;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        sclk = 1'b0;
        repeat (gap - 2) begin
            @(negedge clk);
        end
    endtask

    task automatic load_tx();
        @(negedge clk);
        sclk = 1'b0;
        tx_loaded = 1'b1;
        @(negedge clk);
        tx_loaded = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog act=%0d exp=0", 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(err_flag === 1'b0 && err_irq === 1'b0 && core_rst === 1'b0, "R5 reset", err_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R8: regular frame then long idle
        cur_req = "R8";
        slave_en = 1'b1;
        repeat (7) rise_gap(P);
        rise_fd(P);
        idle(80);
        chk(err_flag === 1'b0, "R8 idle after frame", err_flag, 0);

        // R4 boundaries: periods of P/2 and 2P are accepted
        cur_req = "R4";
        rise_gap(P); rise_gap(P/2); rise_gap(2*P); rise_fd(P);
        idle(20);
        chk(err_flag === 1'b0, "R4 boundary periods", err_flag, 0);

        // R4 fast edge, R6 interrupt
        irq_en = 1'b1;
        rise_gap(P); rise_gap(P); rise_gap(3);
        idle(20);
        chk(err_flag === 1'b1, "R4 glitch edge", err_flag, 1);
        chk(irq_seen == 1, "R6 irq pulse", irq_seen, 1);
        chk(rst_seen == 0, "R7 no reset when disabled", rst_seen, 0);
        cur_req = "R5";
        chk(err_flag === 1'b1, "R5 flag held", err_flag, 1);
        clear_flag();
        @(negedge clk);
        chk(err_flag === 1'b0, "R5 flag cleared", err_flag, 0);

        // R3 missing pulse, R7 auto reset, R6 irq off
        cur_req = "R3";
        irq_en = 1'b0;
        arst_en = 1'b1;
        rise_gap(P); rise_gap(P);
        idle(30);
        chk(err_flag === 1'b1, "R3 stall in frame", err_flag, 1);
        chk(rst_seen == 1, "R7 reset pulse", rst_seen, 1);
        chk(irq_seen == 1, "R6 irq gated off", irq_seen, 1);
        chk(err_flag === 1'b1, "R7 flag kept after reset", err_flag, 1);
        clear_flag();
        arst_en = 1'b0;

        // R9, R10: back-to-back frame with a close first edge
        cur_req = "R10";
        rise_gap(P); rise_gap(P);
        load_tx();
        rise_gap(P);
        rise_fd(2);
        rise_gap(P); rise_gap(P);
        rise_fd(P);
        idle(40);
        chk(err_flag === 1'b0, "R10 chained first edge exempt", err_flag, 0);

        // R9: load pending, master stops
        cur_req = "R9";
        rise_gap(P); rise_gap(P);
        load_tx();
        rise_fd(P);
        idle(30);
        chk(err_flag === 1'b1, "R9 stopped after chained frame", err_flag, 1);
        clear_flag();

        // R1: slave inactive
        cur_req = "R1";
        rise_gap(P); rise_gap(P);
        @(negedge clk);
        slave_en = 1'b0;
        idle(40);
        repeat (4) rise_gap(2);
        idle(10);
        chk(err_flag === 1'b0, "R1 no check while inactive", err_flag, 0);
        slave_en = 1'b1;

        // R11: after an error the next edge starts fresh
        cur_req = "R11";
        rise_gap(P); rise_gap(2);
        rise_gap(3); rise_gap(P); rise_gap(P);
        idle(2);
        chk(err_flag === 1'b1, "R11 error seen", err_flag, 1);
        clear_flag();
        rise_gap(P); rise_fd(P);
        idle(20);
        chk(err_flag === 1'b0, "R11 restart without error", err_flag, 0);

        idle(5);
        finish_run();
    end

endmodule